// File: doc/BRIEF.md
# MSI Doorbell to Indicator-Bit Interrupt Converter

This unit turns a write to a message-signalled-interrupt doorbell into bit updates in memory-resident indicator arrays, followed where needed by an adapter interrupt. The doorbell data word holds a function identifier in its upper bits and a vector number in its low `VEC_BITS` bits. The unit looks the identifier up in a small table of per-function routing settings. These settings come in on ports and are programmed elsewhere.

For a known, enabled function, the unit ORs one bit into the function's vector indicator array. It then ORs one bit into the function's summary array. Both updates use a byte-wide atomic read-modify-write memory port that returns the old byte. An interrupt word is produced only when the summary bit was clear before the update. An identifier that matches no function produces an error event. A function that is present but disabled is ignored. A failed memory access produces a separate error event and ends the operation without an interrupt.

Top module: `msi_ind_unit`

## Requirements
- R1: The doorbell data is split so that the function id is `data >> VEC_BITS` and the vector is the low `VEC_BITS` bits. The id is matched against the table entries whose present flag is set, and the lowest matching index wins.
- R2: An id that matches no present entry produces a one-cycle `evt_valid` pulse with `evt_code` = 8'h01, `evt_fid` = the id, `evt_addr` = the doorbell address and `evt_qual` = vector << 16. It causes no memory access and no interrupt.
- R3: A matched entry whose enable flag is clear is ignored: no memory access, no event and no interrupt.
- R4: Indicator update: bit = indicator offset + vector. The byte address is the indicator base + bit/8 and the OR mask is 8'h80 >> (bit mod 8), so the bits are numbered MSB-first. Every request carries exactly one mask bit.
- R5: Summary update: the byte address is the summary base + summary offset/8 and the mask is 8'h80 >> (summary offset mod 8).
- R6: The indicator request is issued before the summary request, with one request at a time. A request, with its address and mask, is held until `mem_rsp_valid`.
- R7: A one-cycle `irq_valid` pulse follows the summary response only when the returned old byte had the summary bit clear. `irq_word` = 32'h8000_0000 | (isc << 27).
- R8: A response with `mem_rsp_err` set produces `evt_code` = 8'h02 with `evt_addr` = the failing byte address and `evt_qual` = 0. The operation stops there: no summary request after a failed indicator access, and no interrupt.
- R9: A doorbell read (`rd_en`) is answered one cycle later with `rd_valid` set and `rd_data` = 0.
- R10: During and after reset, `db_ready` is high and `mem_req`, `irq_valid`, `evt_valid` and `rd_valid` are low.
- R11: `db_ready` is low from the cycle after a doorbell is accepted until its processing ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_ready | output | 1 | Unit idle, doorbell write accepted |
| db_addr | input | ADDR_W | Doorbell write address |
| db_data | input | DATA_W | Doorbell write data (id and vector) |
| rd_en | input | 1 | Doorbell read strobe |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | DATA_W | Read answer data (always zero) |
| fn_present | input | NF | Per-entry present flag |
| fn_enable | input | NF | Per-entry enable flag |
| fn_fid | input | NF*FID_W | Per-entry function id |
| fn_ind_base | input | NF*ADDR_W | Per-entry indicator array base |
| fn_ind_off | input | NF*OFF_W | Per-entry indicator bit offset |
| fn_sum_base | input | NF*ADDR_W | Per-entry summary array base |
| fn_sum_off | input | NF*OFF_W | Per-entry summary bit offset |
| fn_isc | input | NF*ISC_W | Per-entry interrupt subclass |
| mem_req | output | 1 | Atomic OR request |
| mem_addr | output | ADDR_W | Byte address |
| mem_mask | output | 8 | Byte OR mask |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 8 | Byte value before the OR |
| mem_rsp_err | input | 1 | Access failed |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_word | output | 32 | Interrupt word |
| evt_valid | output | 1 | Error event pulse |
| evt_code | output | 8 | Event code |
| evt_fid | output | FID_W | Event function id |
| evt_addr | output | ADDR_W | Event address |
| evt_qual | output | 32 | Event qualifier |

## Verification
The first doorbell writes to fresh memory and must raise an interrupt. A second vector of the same function sets a bit in a different indicator byte and must not raise one, which separates the summary bit's 0-to-1 transition from a fixed per-doorbell interrupt. A second function shares the summary byte with the first but uses a different bit. The byte is then non-zero while the bit is clear, which tells a per-bit test from a per-byte test. The same function also checks the MSB-first mask at bit 7. The remaining patterns are a disabled entry, an unknown id, and forced errors on each of the two accesses, with the access log showing order and abort.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_IND    = 2'd2,
    ST_SUM    = 2'd3
  } ctl_state_e;

  localparam logic [7:0]  EVT_NO_FUNC = 8'h01;
  localparam logic [7:0]  EVT_IND_ERR = 8'h02;
  localparam logic [31:0] IRQ_AI_FLAG = 32'h8000_0000;
  localparam int          ISC_LSB     = 27;
endpackage

// File: rtl/msi_fn_lookup.sv
module msi_fn_lookup #(
  parameter int NF    = 4,
  parameter int FID_W = 24,
  localparam int IDX_W = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [FID_W-1:0]    fid,
  input  logic [NF-1:0]       present,
  input  logic [NF*FID_W-1:0] table_fid,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  logic [NF-1:0] match;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign match[i] = present[i] && (table_fid[i*FID_W +: FID_W] == fid);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int VEC_BITS = 8,
  localparam int BIT_W   = OFF_W + 1
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [OFF_W-1:0]    offset,
  input  logic [VEC_BITS-1:0] vec,
  output logic [ADDR_W-1:0]   byte_addr,
  output logic [7:0]          byte_mask
);
  logic [BIT_W-1:0] bitnum;

  assign bitnum    = BIT_W'(offset) + BIT_W'(vec);
  assign byte_addr = base + ADDR_W'(bitnum >> 3);
  assign byte_mask = 8'h80 >> bitnum[2:0];
endmodule

// File: rtl/msi_ind_unit.sv
module msi_ind_unit
  import msi_ind_pkg::*;
#(
  parameter int NF       = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int VEC_BITS = 8,
  parameter int OFF_W    = 16,
  parameter int ISC_W    = 3,
  parameter int QUAL_LSB = 16,
  localparam int FID_W   = DATA_W - VEC_BITS,
  localparam int IDX_W   = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 db_valid,
  output logic                 db_ready,
  input  logic [ADDR_W-1:0]    db_addr,
  input  logic [DATA_W-1:0]    db_data,
  input  logic                 rd_en,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NF-1:0]        fn_present,
  input  logic [NF-1:0]        fn_enable,
  input  logic [NF*FID_W-1:0]  fn_fid,
  input  logic [NF*ADDR_W-1:0] fn_ind_base,
  input  logic [NF*OFF_W-1:0]  fn_ind_off,
  input  logic [NF*ADDR_W-1:0] fn_sum_base,
  input  logic [NF*OFF_W-1:0]  fn_sum_off,
  input  logic [NF*ISC_W-1:0]  fn_isc,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_mask,
  input  logic                 mem_rsp_valid,
  input  logic [7:0]           mem_rsp_data,
  input  logic                 mem_rsp_err,
  output logic                 irq_valid,
  output logic [31:0]          irq_word,
  output logic                 evt_valid,
  output logic [7:0]           evt_code,
  output logic [FID_W-1:0]     evt_fid,
  output logic [ADDR_W-1:0]    evt_addr,
  output logic [31:0]          evt_qual
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  // unpacked view of the routing table
  logic [ADDR_W-1:0] ind_base_a [NF];
  logic [OFF_W-1:0]  ind_off_a  [NF];
  logic [ADDR_W-1:0] sum_base_a [NF];
  logic [OFF_W-1:0]  sum_off_a  [NF];
  logic [ISC_W-1:0]  isc_a      [NF];
  for (genvar i = 0; i < NF; i++) begin : g_tbl
    assign ind_base_a[i] = fn_ind_base[i*ADDR_W +: ADDR_W];
    assign ind_off_a[i]  = fn_ind_off[i*OFF_W +: OFF_W];
    assign sum_base_a[i] = fn_sum_base[i*ADDR_W +: ADDR_W];
    assign sum_off_a[i]  = fn_sum_off[i*OFF_W +: OFF_W];
    assign isc_a[i]      = fn_isc[i*ISC_W +: ISC_W];
  end

  ctl_state_e          state_q, state_d;
  logic [FID_W-1:0]    fid_q;
  logic [VEC_BITS-1:0] vec_q;
  logic [ADDR_W-1:0]   dba_q;
  logic                load;

  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;

  msi_fn_lookup #(.NF(NF), .FID_W(FID_W)) u_lookup (
    .fid       (fid_q),
    .present   (fn_present),
    .table_fid (fn_fid),
    .hit       (lk_hit),
    .idx       (lk_idx)
  );

  logic [ADDR_W-1:0] ind_addr, sum_addr;
  logic [7:0]        ind_mask, sum_mask;

  msi_bit_locator #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_BITS(VEC_BITS)) u_ind_loc (
    .base      (ind_base_a[lk_idx]),
    .offset    (ind_off_a[lk_idx]),
    .vec       (vec_q),
    .byte_addr (ind_addr),
    .byte_mask (ind_mask)
  );

  msi_bit_locator #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_BITS(VEC_BITS)) u_sum_loc (
    .base      (sum_base_a[lk_idx]),
    .offset    (sum_off_a[lk_idx]),
    .vec       ('0),
    .byte_addr (sum_addr),
    .byte_mask (sum_mask)
  );

  // next-state logic
  logic              irq_set, evt_set;
  logic [7:0]        evt_code_d;
  logic [ADDR_W-1:0] evt_addr_d;
  logic [31:0]       evt_qual_d;

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    irq_set    = 1'b0;
    evt_set    = 1'b0;
    evt_code_d = EVT_NO_FUNC;
    evt_addr_d = dba_q;
    evt_qual_d = 32'(vec_q) << QUAL_LSB;
    unique case (state_q)
      ST_IDLE: begin
        if (db_valid) begin
          load    = 1'b1;
          state_d = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (!lk_hit) begin
          evt_set = 1'b1;
          state_d = ST_IDLE;
        end else if (!fn_enable[lk_idx]) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_IND;
        end
      end
      ST_IND: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            evt_set    = 1'b1;
            evt_code_d = EVT_IND_ERR;
            evt_addr_d = ind_addr;
            evt_qual_d = '0;
            state_d    = ST_IDLE;
          end else begin
            state_d = ST_SUM;
          end
        end
      end
      ST_SUM: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          if (mem_rsp_err) begin
            evt_set    = 1'b1;
            evt_code_d = EVT_IND_ERR;
            evt_addr_d = sum_addr;
            evt_qual_d = '0;
          end else if ((mem_rsp_data & sum_mask) == 8'h00) begin
            irq_set = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= ST_IDLE;
      fid_q     <= '0;
      vec_q     <= '0;
      dba_q     <= '0;
      irq_valid <= 1'b0;
      irq_word  <= '0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_fid   <= '0;
      evt_addr  <= '0;
      evt_qual  <= '0;
      rd_valid  <= 1'b0;
    end else begin
      state_q   <= state_d;
      irq_valid <= irq_set;
      evt_valid <= evt_set;
      rd_valid  <= rd_en;
      if (load) begin
        fid_q <= db_data[DATA_W-1:VEC_BITS];
        vec_q <= db_data[VEC_BITS-1:0];
        dba_q <= db_addr;
      end
      if (irq_set) begin
        irq_word <= IRQ_AI_FLAG | (32'(isc_a[lk_idx]) << ISC_LSB);
      end
      if (evt_set) begin
        evt_code <= evt_code_d;
        evt_fid  <= fid_q;
        evt_addr <= evt_addr_d;
        evt_qual <= evt_qual_d;
      end
    end
  end

  assign rd_data  = '0;
  assign db_ready = (state_q == ST_IDLE);
  assign mem_req  = (state_q == ST_IND) || (state_q == ST_SUM);
  assign mem_addr = (state_q == ST_SUM) ? sum_addr : ind_addr;
  assign mem_mask = (state_q == ST_SUM) ? sum_mask : ind_mask;
endmodule

// File: rtl/msi_ind_unit_chk.sv
module msi_ind_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_mask,
  input logic              mem_rsp_valid,
  input logic [7:0]        mem_rsp_data,
  input logic              mem_rsp_err,
  input logic              irq_valid,
  input logic              evt_valid
);
  // R6: request held steady until answered
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_mask)));

  // R4: one mask bit per request
  assert_mask_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_mask) == 1));

  // R7: interrupt only after an error-free response whose masked old bit was clear
  assert_irq_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(mem_rsp_valid) && !$past(mem_rsp_err) &&
                   (($past(mem_rsp_data) & $past(mem_mask)) == 8'h00)));

  // R8: error response never followed by an interrupt
  assert_no_irq_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_err) |=> !irq_valid);

  // R8: interrupt and event never together
  assert_irq_evt_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && evt_valid));

  // R11: busy while memory is in use
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !db_ready);
endmodule

bind msi_ind_unit msi_ind_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .db_ready      (db_ready),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_mask      (mem_mask),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .mem_rsp_err   (mem_rsp_err),
  .irq_valid     (irq_valid),
  .evt_valid     (evt_valid)
);

// File: tb/tb_msi_ind_unit.sv
module tb_msi_ind_unit;
  localparam int NF = 4, AW = 32, DW = 32, VB = 8, OW = 16, IW = 3;
  localparam int FW = DW - VB;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic db_valid, db_ready, rd_en, rd_valid;
  logic [AW-1:0] db_addr;
  logic [DW-1:0] db_data, rd_data;
  logic [NF-1:0] fn_present, fn_enable;
  logic [NF*FW-1:0] fn_fid;
  logic [NF*AW-1:0] fn_ind_base, fn_sum_base;
  logic [NF*OW-1:0] fn_ind_off, fn_sum_off;
  logic [NF*IW-1:0] fn_isc;
  logic mem_req, mem_rsp_valid, mem_rsp_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_mask, mem_rsp_data;
  logic irq_valid, evt_valid;
  logic [31:0] irq_word, evt_qual;
  logic [7:0] evt_code;
  logic [FW-1:0] evt_fid;
  logic [AW-1:0] evt_addr;

  msi_ind_unit dut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_ready(db_ready),
    .db_addr(db_addr), .db_data(db_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .fn_present(fn_present), .fn_enable(fn_enable),
    .fn_fid(fn_fid), .fn_ind_base(fn_ind_base), .fn_ind_off(fn_ind_off),
    .fn_sum_base(fn_sum_base), .fn_sum_off(fn_sum_off), .fn_isc(fn_isc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_mask(mem_mask),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .irq_valid(irq_valid), .irq_word(irq_word),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_fid(evt_fid),
    .evt_addr(evt_addr), .evt_qual(evt_qual)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model: atomic OR, answers one request at a time
  logic [7:0] mem [256];
  bit err_en = 0;
  logic [7:0] err_addr = 8'h00;
  int n_acc = 0;
  logic [7:0] acc_log [8];

  always @(negedge clk) begin
    if (mem_req && !mem_rsp_valid) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_addr[7:0]];
      if (n_acc < 8) acc_log[n_acc] <= mem_addr[7:0];
      n_acc <= n_acc + 1;
      if (err_en && mem_addr[7:0] == err_addr) mem_rsp_err <= 1'b1;
      else begin
        mem_rsp_err <= 1'b0;
        mem[mem_addr[7:0]] <= mem[mem_addr[7:0]] | mem_mask;
      end
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end
  end

  // pulse monitor
  int n_irq = 0, n_evt = 0;
  logic [31:0] last_irq;
  logic [7:0] last_code;
  logic [FW-1:0] last_fid;
  logic [AW-1:0] last_eaddr;
  logic [31:0] last_qual;
  always @(negedge clk) begin
    if (irq_valid) begin n_irq <= n_irq + 1; last_irq <= irq_word; end
    if (evt_valid) begin
      n_evt <= n_evt + 1; last_code <= evt_code; last_fid <= evt_fid;
      last_eaddr <= evt_addr; last_qual <= evt_qual;
    end
  end

  task automatic clear_counts();
    @(negedge clk);
    n_acc = 0; n_irq = 0; n_evt = 0;
  endtask

  task automatic doorbell(input logic [FW-1:0] fid, input logic [VB-1:0] vec,
                          input logic [AW-1:0] addr, input bit check_busy);
    @(negedge clk);
    while (!db_ready) @(negedge clk);
    db_valid = 1'b1; db_data = {fid, vec}; db_addr = addr;
    @(negedge clk);
    db_valid = 1'b0;
    if (check_busy) chk(db_ready == 1'b0, "R11", "db_ready after accept", db_ready, 0);
    while (!db_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(db_ready == 1'b1, "R10", "db_ready in reset", db_ready, 1);
    chk(!mem_req && !irq_valid && !evt_valid && !rd_valid, "R10", "outputs idle",
        {mem_req, irq_valid, evt_valid, rd_valid}, 0);
  endtask

  task automatic t_first_vec();
    clear_counts();
    doorbell(24'h10, 8'd0, 32'h1000, 1);
    chk(mem[8'h20] == 8'h10, "R4", "indicator byte fn0 v0", mem[8'h20], 8'h10);
    chk(mem[8'h80] == 8'h04, "R5", "summary byte fn0", mem[8'h80], 8'h04);
    chk(n_acc == 2 && acc_log[0] == 8'h20 && acc_log[1] == 8'h80, "R6",
        "access order", {acc_log[0], acc_log[1]}, 16'h2080);
    chk(n_irq == 1, "R7", "irq count on fresh summary", n_irq, 1);
    chk(last_irq == 32'hA800_0000, "R7", "irq word isc5", last_irq, 32'hA800_0000);
    chk(n_evt == 0, "R1", "no event for known id", n_evt, 0);
  endtask

  task automatic t_summary_set();
    clear_counts();
    doorbell(24'h10, 8'd13, 32'h1000, 0);
    chk(mem[8'h22] == 8'h80, "R4", "indicator byte crossing", mem[8'h22], 8'h80);
    chk(n_irq == 0, "R7", "no irq when summary set", n_irq, 0);
  endtask

  task automatic t_shared_byte();
    clear_counts();
    doorbell(24'h33, 8'd7, 32'h1000, 0);
    chk(mem[8'h40] == 8'h01, "R4", "indicator bit7 mask", mem[8'h40], 8'h01);
    chk(mem[8'h80] == 8'h06, "R5", "summary byte shared", mem[8'h80], 8'h06);
    chk(n_irq == 1 && last_irq == 32'h9000_0000, "R7", "irq per bit not byte",
        last_irq, 32'h9000_0000);
  endtask

  task automatic t_disabled();
    clear_counts();
    doorbell(24'h22, 8'd2, 32'h1000, 0);
    chk(n_acc == 0 && n_irq == 0 && n_evt == 0, "R3", "disabled ignored",
        n_acc + n_irq + n_evt, 0);
  endtask

  task automatic t_unknown();
    clear_counts();
    doorbell(24'h55, 8'h3C, 32'h1234, 0);
    chk(n_evt == 1 && last_code == 8'h01, "R2", "no-func event code", last_code, 1);
    chk(last_fid == 24'h55 && last_eaddr == 32'h1234, "R2", "event fid/addr",
        {last_fid, last_eaddr}, {24'h55, 32'h1234});
    chk(last_qual == 32'h003C_0000, "R2", "event qualifier", last_qual, 32'h003C_0000);
    chk(n_acc == 0 && n_irq == 0, "R2", "no access/irq", n_acc + n_irq, 0);
  endtask

  task automatic t_ind_err();
    mem[8'h80] = 8'h00;
    err_en = 1; err_addr = 8'h22;
    clear_counts();
    doorbell(24'h10, 8'd20, 32'h1000, 0);
    chk(n_evt == 1 && last_code == 8'h02 && last_eaddr == 32'h22, "R8",
        "indicator error event", {last_code, last_eaddr[7:0]}, 16'h0222);
    chk(n_acc == 1 && n_irq == 0, "R8", "abort before summary", n_acc, 1);
    chk(mem[8'h80] == 8'h00, "R8", "summary untouched", mem[8'h80], 0);
    err_en = 0;
  endtask

  task automatic t_sum_err();
    err_en = 1; err_addr = 8'h80;
    clear_counts();
    doorbell(24'h33, 8'd1, 32'h1000, 0);
    chk(n_acc == 2 && n_evt == 1 && last_eaddr == 32'h80 && last_qual == 0, "R8",
        "summary error event", last_eaddr, 32'h80);
    chk(n_irq == 0, "R8", "no irq on summary error", n_irq, 0);
    err_en = 0;
  endtask

  task automatic t_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1 && rd_data == 0, "R9", "doorbell read zero", rd_data, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    db_valid = 0; db_data = '0; db_addr = '0; rd_en = 0;
    mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = 0;
    fn_present  = 4'b0111;
    fn_enable   = 4'b0101;
    fn_fid      = {24'h77, 24'h33, 24'h22, 24'h10};
    fn_ind_base = {32'h60, 32'h40, 32'h30, 32'h20};
    fn_ind_off  = {16'd0, 16'd0, 16'd0, 16'd3};
    fn_sum_base = {32'h90, 32'h80, 32'h88, 32'h80};
    fn_sum_off  = {16'd0, 16'd6, 16'd0, 16'd5};
    fn_isc      = {3'd1, 3'd2, 3'd3, 3'd5};
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_first_vec();
    t_summary_set();
    t_shared_byte();
    t_disabled();
    t_unknown();
    t_ind_err();
    t_sum_err();
    t_read();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule